// File: doc/BRIEF.md
# SPI Receiver Register Sequencer

This block owns the control port of an audio receiver that sits behind an 8-bit SPI link with byte-addressed registers. Coming out of reset it brings the receiver up on its own. It holds the receiver's reset line low, releases it and waits. It then toggles chip select once to put the receiver into its serial-control mode, and writes ten default register values. After that it serves single-register reads and writes from a request/acknowledge port.

All waits are counted in microsecond ticks. A divider derives those ticks from the system clock frequency parameter, and the serial clock half-period is derived the same way. A read costs two chip-select frames, while a write costs one.

The controller is a single state machine with these states:
- `ST_RST_LOW`: receiver reset is driven low.
- `ST_RST_WAIT`: reset has been released and the block is waiting.
- `ST_SEL_HI`, `ST_SEL_LO`, `ST_SEL_END`: the three levels of the mode-select pulse.
- `ST_CS_SETUP`: chip select is low and the setup gap is counting.
- `ST_SHIFT`: bytes are being shifted.
- `ST_CS_GAP`: chip select is high and the recovery gap is counting.
- `ST_IDLE`: waiting for a request.

Transitions:
- Each timed state moves on when its wait expires, in the order `ST_RST_LOW` → `ST_RST_WAIT` → `ST_SEL_HI` → `ST_SEL_LO` → `ST_SEL_END` → `ST_CS_SETUP`.
- `ST_CS_SETUP` → `ST_SHIFT` when the setup gap ends.
- `ST_SHIFT` → `ST_CS_GAP` when the last byte of the frame is done.
- `ST_CS_GAP` → `ST_CS_SETUP` when another frame is due (the next init register, or the second frame of a read).
- `ST_CS_GAP` → `ST_IDLE` otherwise, raising `init_done` after the tenth init write or `ack` after a request.
- `ST_IDLE` → `ST_CS_SETUP` on an accepted request.

Top module: `rxcfg_seq`

## Requirements
- R1: While `rst_n` is low and for RST_LOW_US microseconds after it rises, `rx_rst_n` is 0. During that time `spi_cs_n` is 1, `spi_sck` is 1, and `ack` and `init_done` are 0. Then `rx_rst_n` goes to 1 and stays there.
- R2: After a further RST_WAIT_US plus SEL_STEP_US microseconds with chip select high, `spi_cs_n` goes low for at least SEL_STEP_US microseconds with no clock edges, then returns high. This pulse is the first chip-select frame.
- R3: Each byte is 8 serial clocks in SPI mode 3. `spi_sck` idles high and is never low while `spi_cs_n` is high. Bits go out most-significant first, `spi_mosi` changes on the falling edge, and `spi_miso` is sampled on the rising edge. The low phase of the clock lasts CLK_HZ/(2*SCK_HZ) system clocks.
- R4: Initialization then writes registers 0 through 9 in ascending order. Each write is its own frame. The values are 0x48 for register 2, 0x80 for register 4, 0x85 for register 5 and 0x00 for all the others.
- R5: A write request (`we`=1) produces one frame of three bytes: 0x20, then `addr`, then `wdata`.
- R6: A read request (`we`=0) produces two frames. The first is 0x20 followed by `addr`. The second is 0x21 followed by 0x00. `rdata` takes the byte received during the 0x00 byte.
- R7: At least GAP_US microseconds separate a falling chip select from the first serial clock edge. At least GAP_US microseconds also separate the end of a frame from the next falling chip select.
- R8: `init_done` rises after the last init frame and never falls. A request made while `init_done` is 0 is dropped: it produces no frame and no `ack`.
- R9: Each request gets exactly one single-cycle `ack` once its last frame has ended. `rdata` changes only on the `ack` of a read and holds its value across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, held until `ack` |
| we | input | 1 | 1 selects a write, 0 selects a read |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Result of the last read |
| init_done | output | 1 | Power-up sequence complete |
| rx_rst_n | output | 1 | Reset to the receiver, active low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the receiver |
| spi_miso | input | 1 | Serial data from the receiver |

## Verification
The bench models the receiver as a register file behind the serial pins, so it catches a read whose frames are merged or whose command byte is wrong. In that case the model returns nothing and `rdata` mismatches. A request raised in the middle of initialization checks that early requests are dropped. A design that queued the request would emit an eleventh init frame, and reading that register later would not return its untouched value. Edge timing is measured to check that the serial clock low phase lasts exactly half a period and that both chip-select gaps are at least the set length; an off-by-one half-period or a missing gap shows up directly. A write placed between reads checks that `rdata` holds, because a design that loaded `rdata` on every `ack` would change it.

// File: rtl/rxcfg_pkg.sv
package rxcfg_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned INIT_REGS = 10;
    localparam int unsigned IDX_W     = $clog2(INIT_REGS);

    localparam logic [BYTE_W-1:0] CMD_WRITE = 8'h20;
    localparam logic [BYTE_W-1:0] CMD_READ  = 8'h21;
    localparam logic [BYTE_W-1:0] FILL_BYTE = 8'h00;

    typedef enum logic [3:0] {
        ST_RST_LOW,
        ST_RST_WAIT,
        ST_SEL_HI,
        ST_SEL_LO,
        ST_SEL_END,
        ST_CS_SETUP,
        ST_SHIFT,
        ST_CS_GAP,
        ST_IDLE
    } seq_state_t;

    // default contents written during bring-up, indexed by register number
    function automatic logic [BYTE_W-1:0] boot_value(input logic [IDX_W-1:0] idx);
        case (idx)
            IDX_W'(2): boot_value = 8'h48;
            IDX_W'(4): boot_value = 8'h80;
            IDX_W'(5): boot_value = 8'h85;
            default:   boot_value = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/rxcfg_tick.sv
module rxcfg_tick #(
    parameter int unsigned DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (clr) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/rxcfg_spi_byte.sv
module rxcfg_spi_byte #(
    parameter int unsigned HALF = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx
);
    localparam int unsigned HW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [HW-1:0] hc;
    logic [2:0]    bc;
    logic [7:0]    sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck  <= 1'b1;
            mosi <= 1'b0;
            busy <= 1'b0;
            done <= 1'b0;
            hc   <= '0;
            bc   <= '0;
            sh   <= '0;
            rx   <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    sck  <= 1'b0;
                    mosi <= tx[7];
                    sh   <= {tx[6:0], 1'b0};
                    hc   <= '0;
                    bc   <= '0;
                end
            end else if (hc == HW'(HALF - 1)) begin
                hc <= '0;
                if (!sck) begin
                    sck <= 1'b1;
                    rx  <= {rx[6:0], miso};
                end else if (bc == 3'd7) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    sck  <= 1'b0;
                    bc   <= bc + 3'd1;
                    mosi <= sh[7];
                    sh   <= {sh[6:0], 1'b0};
                end
            end else begin
                hc <= hc + 1'b1;
            end
        end
    end

    // R3: clock parks high whenever no byte is in flight
    a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck);
    // R3: a rising clock edge only occurs inside a byte
    a_r3_rise_in_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> busy);

endmodule

// File: rtl/rxcfg_seq.sv
module rxcfg_seq
    import rxcfg_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned SCK_HZ      = 1_000_000,
    parameter int unsigned GAP_US      = 10,
    parameter int unsigned RST_LOW_US  = 100_000,
    parameter int unsigned RST_WAIT_US = 1_000,
    parameter int unsigned SEL_STEP_US = 1_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       we,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic       ack,
    output logic [7:0] rdata,
    output logic       init_done,
    output logic       rx_rst_n,
    output logic       spi_cs_n,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    localparam int unsigned US_DIV   = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
    localparam int unsigned HALF_CYC = (CLK_HZ / (2 * SCK_HZ) > 0) ? CLK_HZ / (2 * SCK_HZ) : 1;
    localparam int unsigned MAX_A    = (RST_LOW_US > RST_WAIT_US) ? RST_LOW_US : RST_WAIT_US;
    localparam int unsigned MAX_B    = (SEL_STEP_US > GAP_US) ? SEL_STEP_US : GAP_US;
    localparam int unsigned MAX_W    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned WCW      = $clog2(MAX_W + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(INIT_REGS - 1);

    seq_state_t         state, state_n;
    logic [WCW-1:0]     wcnt, ld_val;
    logic               ld, go, tick, wait_end;
    logic [1:0]         bidx, sel, last_idx;
    logic [IDX_W-1:0]   init_idx;
    logic               init_busy, rd_phase;
    logic               op_we;
    logic [BYTE_W-1:0]  op_addr, op_wdata, eff_addr, eff_data, tx_byte, sp_rx;
    logic               eff_we, sp_busy, sp_done;

    rxcfg_tick #(.DIV(US_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(ld), .tick(tick)
    );

    rxcfg_spi_byte #(.HALF(HALF_CYC)) u_spi (
        .clk(clk), .rst_n(rst_n), .start(go), .tx(tx_byte), .miso(spi_miso),
        .sck(spi_sck), .mosi(spi_mosi), .busy(sp_busy), .done(sp_done), .rx(sp_rx)
    );

    assign wait_end = tick && (wcnt == WCW'(1));

    // frame content: which byte goes out next
    always_comb begin
        eff_we   = init_busy | op_we;
        eff_addr = init_busy ? BYTE_W'(init_idx) : op_addr;
        eff_data = init_busy ? boot_value(init_idx) : op_wdata;
        last_idx = (eff_we && !rd_phase) ? 2'd2 : 2'd1;
        sel      = (state == ST_SHIFT) ? bidx + 2'd1 : 2'd0;
        if (rd_phase)
            tx_byte = (sel == 2'd0) ? CMD_READ : FILL_BYTE;
        else if (sel == 2'd0)
            tx_byte = CMD_WRITE;
        else if (sel == 2'd1)
            tx_byte = eff_addr;
        else
            tx_byte = eff_data;
    end

    // next state
    always_comb begin
        state_n = state;
        ld      = 1'b0;
        ld_val  = '0;
        go      = 1'b0;
        unique case (state)
            ST_RST_LOW:  if (wait_end) begin state_n = ST_RST_WAIT; ld = 1'b1; ld_val = WCW'(RST_WAIT_US); end
            ST_RST_WAIT: if (wait_end) begin state_n = ST_SEL_HI;   ld = 1'b1; ld_val = WCW'(SEL_STEP_US); end
            ST_SEL_HI:   if (wait_end) begin state_n = ST_SEL_LO;   ld = 1'b1; ld_val = WCW'(SEL_STEP_US); end
            ST_SEL_LO:   if (wait_end) begin state_n = ST_SEL_END;  ld = 1'b1; ld_val = WCW'(SEL_STEP_US); end
            ST_SEL_END:  if (wait_end) begin state_n = ST_CS_SETUP; ld = 1'b1; ld_val = WCW'(GAP_US); end
            ST_CS_SETUP: if (wait_end) begin state_n = ST_SHIFT; go = 1'b1; end
            ST_SHIFT: begin
                if (sp_done) begin
                    if (bidx == last_idx) begin
                        state_n = ST_CS_GAP; ld = 1'b1; ld_val = WCW'(GAP_US);
                    end else begin
                        go = 1'b1;
                    end
                end
            end
            ST_CS_GAP: begin
                if (wait_end) begin
                    if ((init_busy && init_idx != LAST_IDX) || (!init_busy && !op_we && !rd_phase)) begin
                        state_n = ST_CS_SETUP; ld = 1'b1; ld_val = WCW'(GAP_US);
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
            end
            ST_IDLE: if (req && !ack) begin state_n = ST_CS_SETUP; ld = 1'b1; ld_val = WCW'(GAP_US); end
            default: state_n = ST_RST_LOW;
        endcase
    end

    // state register and sequencing data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_RST_LOW;
            wcnt      <= WCW'(RST_LOW_US);
            bidx      <= '0;
            init_idx  <= '0;
            init_busy <= 1'b1;
            init_done <= 1'b0;
            rd_phase  <= 1'b0;
            op_we     <= 1'b0;
            op_addr   <= '0;
            op_wdata  <= '0;
            ack       <= 1'b0;
            rdata     <= '0;
        end else begin
            state <= state_n;
            ack   <= 1'b0;
            if (ld)
                wcnt <= ld_val;
            else if (tick && wcnt != '0)
                wcnt <= wcnt - 1'b1;
            if (go)
                bidx <= sel;
            if (state == ST_IDLE && state_n == ST_CS_SETUP) begin
                op_we    <= we;
                op_addr  <= addr;
                op_wdata <= wdata;
            end
            if (state == ST_CS_GAP && wait_end) begin
                if (init_busy) begin
                    if (init_idx == LAST_IDX) begin
                        init_busy <= 1'b0;
                        init_done <= 1'b1;
                    end else begin
                        init_idx <= init_idx + 1'b1;
                    end
                end else if (!op_we && !rd_phase) begin
                    rd_phase <= 1'b1;
                end else begin
                    ack      <= 1'b1;
                    rd_phase <= 1'b0;
                    if (!op_we)
                        rdata <= sp_rx;
                end
            end
        end
    end

    // pin outputs
    always_comb begin
        rx_rst_n = (state != ST_RST_LOW);
        spi_cs_n = !(state inside {ST_SEL_LO, ST_CS_SETUP, ST_SHIFT});
    end

    // R1: serial pins stay idle while the receiver is held in reset
    a_r1_idle_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_rst_n |-> (spi_cs_n && spi_sck));
    // R3: the clock is only driven low inside a selected frame
    a_r3_sck_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_sck |-> !spi_cs_n);
    // R7: no clock edge directly behind a falling chip select
    a_r7_setup_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |=> spi_sck);
    // R7: the shifter is never running with chip select high
    a_r7_shift_selected: assert property (@(posedge clk) disable iff (!rst_n)
        sp_busy |-> !spi_cs_n);
    // R8: init_done is sticky
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    // R8: no acknowledge before bring-up finished
    a_r8_no_early_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> init_done);
    // R9: acknowledge lasts one cycle
    a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

endmodule

// File: tb/rxcfg_seq_bench.sv
`timescale 1ns/1ps
module rxcfg_seq_bench;
    localparam int CLK_PERIOD  = 250;
    localparam int CLK_HZ      = 4_000_000;
    localparam int SCK_HZ      = 1_000_000;
    localparam int GAP_US      = 3;
    localparam int RST_LOW_US  = 50;
    localparam int RST_WAIT_US = 10;
    localparam int SEL_STEP_US = 10;
    localparam int US_DIV      = CLK_HZ / 1_000_000;
    localparam int HALF_CYC    = CLK_HZ / (2 * SCK_HZ);
    localparam int GAP_CYC     = GAP_US * US_DIV;
    localparam int NVEC        = 12;

    // {we, addr, wdata, expected rdata}
    localparam logic [24:0] VEC [0:NVEC-1] = '{
        {1'b1, 8'h01, 8'h02, 8'h00},
        {1'b0, 8'h01, 8'h00, 8'h02},
        {1'b0, 8'h05, 8'h00, 8'h85},
        {1'b0, 8'h02, 8'h00, 8'h48},
        {1'b1, 8'h04, 8'h88, 8'h00},
        {1'b0, 8'h04, 8'h00, 8'h88},
        {1'b0, 8'h09, 8'h00, 8'h00},
        {1'b1, 8'hFF, 8'hA5, 8'h00},
        {1'b0, 8'hFF, 8'h00, 8'hA5},
        {1'b0, 8'h33, 8'h00, 8'hEE},
        {1'b1, 8'h00, 8'hFF, 8'h00},
        {1'b0, 8'h00, 8'h00, 8'hFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, we = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic ack, init_done, rx_rst_n, spi_cs_n, spi_sck, spi_mosi, spi_miso;
    logic [7:0] rdata;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    rxcfg_seq #(
        .CLK_HZ(CLK_HZ), .SCK_HZ(SCK_HZ), .GAP_US(GAP_US), .RST_LOW_US(RST_LOW_US),
        .RST_WAIT_US(RST_WAIT_US), .SEL_STEP_US(SEL_STEP_US)
    ) u_rxcfg_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .ack(ack), .rdata(rdata), .init_done(init_done), .rx_rst_n(rx_rst_n),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- receiver model behind the serial pins ----------------
    logic [7:0] regs [0:255];
    logic [7:0] fr_b [0:63][0:2];
    int fr_len [0:63];
    int frame_n = 0, cur_len = 0, bitc = 0;
    logic [7:0] shreg = '0, ptr = '0, rd_byte;
    bit in_frame = 0;

    initial for (int i = 0; i < 256; i++) regs[i] = 8'hEE;

    assign rd_byte  = regs[ptr];
    assign spi_miso = (in_frame && cur_len == 1 && fr_b[frame_n][0] == 8'h21) ? rd_byte[7 - bitc] : 1'b0;

    always @(negedge spi_cs_n) if (rst_n) begin
        in_frame = 1; cur_len = 0; bitc = 0; shreg = '0;
    end

    always @(posedge spi_sck) if (rst_n && in_frame && !spi_cs_n) begin
        shreg = {shreg[6:0], spi_mosi};
        if (bitc == 7) begin
            if (cur_len < 3 && frame_n < 64) fr_b[frame_n][cur_len] = shreg;
            cur_len++;
            bitc = 0;
        end else begin
            bitc++;
        end
    end

    always @(posedge spi_cs_n) if (rst_n && in_frame) begin
        in_frame = 0;
        if (frame_n < 64) begin
            fr_len[frame_n] = cur_len;
            if (cur_len == 3 && fr_b[frame_n][0] == 8'h20) regs[fr_b[frame_n][1]] = fr_b[frame_n][2];
            if (cur_len == 2 && fr_b[frame_n][0] == 8'h20) ptr = fr_b[frame_n][1];
        end
        frame_n++;
    end

    // ---------------- pin timing monitor ----------------
    bit prev_cs = 1, prev_sck = 1, rst_rose = 0, sck_started = 0;
    int t_rst_rise = 0, t_csf = 0, t_csr = 0, t_sckf = 0, t_first_csf = 0, t_first_csr = 0;
    int n_csf = 0, n_csr = 0, gap_err = 0, half_err = 0, idle_err = 0, early_ack = 0;

    always @(negedge clk) if (rst_n) begin
        if (!rst_rose && rx_rst_n) begin rst_rose = 1; t_rst_rise = cyc; end
        if (prev_cs && !spi_cs_n) begin
            if (n_csf == 0) t_first_csf = cyc;
            else if (cyc - t_csr < GAP_CYC) gap_err++;
            t_csf = cyc; sck_started = 0; n_csf++;
        end
        if (!prev_cs && spi_cs_n) begin
            if (n_csr == 0) t_first_csr = cyc;
            t_csr = cyc; n_csr++;
        end
        if (prev_sck && !spi_sck) begin
            if (!sck_started) begin
                sck_started = 1;
                if (cyc - t_csf < GAP_CYC) gap_err++;
            end
            t_sckf = cyc;
        end
        if (!prev_sck && spi_sck && (cyc - t_sckf != HALF_CYC)) half_err++;
        if (spi_cs_n && !spi_sck) idle_err++;
        if (ack && !init_done) early_ack++;
        prev_cs = spi_cs_n; prev_sck = spi_sck;
    end

    // ---------------- request driver ----------------
    logic [7:0] last_rd = 8'h00;

    task automatic do_req(input logic w, input logic [7:0] a, input logic [7:0] d, input logic [7:0] exp);
        int fn0;
        fn0 = frame_n;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        while (!ack) @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        chk(!ack, "R9 ack lasts one cycle", ack, 0);
        if (w) begin
            chk(frame_n == fn0 + 1, "R5 one frame per write", frame_n - fn0, 1);
            chk(fr_len[fn0] == 3 && fr_b[fn0][0] == 8'h20 && fr_b[fn0][1] == a && fr_b[fn0][2] == d,
                "R5 write frame bytes", {fr_b[fn0][0], fr_b[fn0][1], fr_b[fn0][2]}, {8'h20, a, d});
            chk(rdata == last_rd, "R9 rdata held across write", rdata, last_rd);
        end else begin
            chk(frame_n == fn0 + 2, "R6 two frames per read", frame_n - fn0, 2);
            chk(fr_len[fn0] == 2 && fr_b[fn0][0] == 8'h20 && fr_b[fn0][1] == a,
                "R6 read address frame", {fr_b[fn0][0], fr_b[fn0][1]}, {8'h20, a});
            chk(fr_len[fn0 + 1] == 2 && fr_b[fn0 + 1][0] == 8'h21 && fr_b[fn0 + 1][1] == 8'h00,
                "R6 read command frame", {fr_b[fn0 + 1][0], fr_b[fn0 + 1][1]}, 16'h2100);
            chk(rdata == exp, "R6 read data", rdata, exp);
            last_rd = exp;
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish actual=%0d expected=done", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rx_rst_n == 0, "R1 receiver reset low", rx_rst_n, 0);
        chk(spi_cs_n == 1, "R1 chip select idle", spi_cs_n, 1);
        chk(spi_sck == 1, "R1 sck idle", spi_sck, 1);
        chk(init_done == 0, "R1 init_done low", init_done, 0);
        chk(ack == 0, "R1 ack low", ack, 0);

        // R8: request while still initializing must be dropped
        while (frame_n < 3) @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 8'h33; wdata = 8'h5A;
        @(negedge clk);
        req = 1'b0;
        while (!init_done) @(negedge clk);

        chk(t_rst_rise >= RST_LOW_US * US_DIV && t_rst_rise <= RST_LOW_US * US_DIV + 12,
            "R1 reset low duration", t_rst_rise, RST_LOW_US * US_DIV);
        chk(t_first_csf - t_rst_rise >= (RST_WAIT_US + SEL_STEP_US) * US_DIV,
            "R2 wait before select pulse", t_first_csf - t_rst_rise, (RST_WAIT_US + SEL_STEP_US) * US_DIV);
        chk(t_first_csr - t_first_csf >= SEL_STEP_US * US_DIV,
            "R2 select pulse low width", t_first_csr - t_first_csf, SEL_STEP_US * US_DIV);
        chk(fr_len[0] == 0, "R2 select pulse carries no clock", fr_len[0], 0);
        chk(frame_n == 11, "R8 early request produced no frame", frame_n, 11);
        for (int i = 0; i < 10; i++) begin
            logic [7:0] dv;
            dv = (i == 2) ? 8'h48 : (i == 4) ? 8'h80 : (i == 5) ? 8'h85 : 8'h00;
            chk(fr_len[i + 1] == 3 && fr_b[i + 1][0] == 8'h20 && fr_b[i + 1][1] == i && fr_b[i + 1][2] == dv,
                "R4 init frame", {fr_b[i + 1][0], fr_b[i + 1][1], fr_b[i + 1][2]}, {8'h20, 8'(i), dv});
        end

        for (int v = 0; v < NVEC; v++)
            do_req(VEC[v][24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);

        repeat (20) @(negedge clk);
        chk(init_done == 1, "R8 init_done stays high", init_done, 1);
        chk(early_ack == 0, "R8 no ack before init", early_ack, 0);
        chk(half_err == 0, "R3 sck low phase length", half_err, 0);
        chk(idle_err == 0, "R3 sck high while deselected", idle_err, 0);
        chk(gap_err == 0, "R7 chip select gaps", gap_err, 0);

        finished = 1;
        summary();
        $finish;
    end

endmodule